// File: doc/BRIEF.md
# Branch Target Unit with Runtime Address Width

This block works out where execution goes next after a jump instruction. It covers absolute and relative jumps. Each kind comes in three forms: always taken, taken when the zero flag is set, and taken when the zero flag is clear. The decoder sends in the opcode and the instruction pointer, already moved past the operand. It also sends the raw operand bytes, the current address-width code, the zero flag and the size of memory. One clock later the block returns the next pointer and a flag that says whether the branch was taken.

The address width is runtime state, not a build-time choice. It sets how many operand bytes count. It also sets the width from which a relative offset is sign-extended. Every result, taken or not, is reduced modulo the memory size. A build parameter can replace the general remainder with a mask when memory is known to be a power of two in size.

Top module: `branch_target_unit`

## Requirements
- R1: While `rst_n` is low, and until the first request is accepted, `out_valid`, `taken` and `next_ptr` are all zero.
- R2: `out_valid` is high exactly one clock after a cycle with `in_valid` high, and low one clock after a cycle with `in_valid` low. `next_ptr` and `taken` are valid in that same cycle.
- R3: Opcode 4 is an unconditional absolute jump. It is always taken, and its target is the operand zero-extended from the address width.
- R4: Opcode 5 (absolute, taken if `zflag`=1) and opcode 6 (absolute, taken if `zflag`=0) use the absolute target when taken.
- R5: Opcode 7 is an unconditional relative jump. It is always taken, and its target is `ptr` plus the operand sign-extended from the address width, with the sum wrapping at 2^64.
- R6: Opcode 8 (relative, taken if `zflag`=1) and opcode 9 (relative, taken if `zflag`=0) use the relative target when taken.
- R7: A conditional jump that is not taken, and any opcode outside 4..9, gives `taken`=0 and `next_ptr` = `ptr` mod `mem_size`.
- R8: `next_ptr` is always the selected value mod `mem_size`, so it is below `mem_size`. With `POW2_SIZE`=1 and a power-of-two `mem_size`, the result is the same.
- R9: The operand is little-endian: byte k sits in `operand[8k+7:8k]`. Width codes 1, 2, 3 and 4 select 1, 2, 4 and 8 bytes. Bytes above the selected width have no effect on the target.
- R10: A width code outside 1..4 is treated as the full 8-byte width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| opcode | input | 8 | Decoded opcode |
| ptr | input | AW | Instruction pointer past the operand |
| operand | input | AW | Operand bytes, little-endian |
| width_code | input | 3 | Address-width code |
| zflag | input | 1 | Zero flag |
| mem_size | input | AW | Memory size in bytes, nonzero |
| out_valid | output | 1 | Result valid |
| next_ptr | output | AW | Next instruction pointer |
| taken | output | 1 | Branch taken |

## Verification
The bench goes after negative relative offsets at every width. If the offset were zero-extended instead of sign-extended, the jump would land far forward instead of backward. A backward jump from a small pointer goes below zero, and so does the 64-bit sum. A design that reduced only the low bits, or dropped the carry, would return the wrong remainder.

The bench also puts nonzero bytes above the selected width. If those bytes leaked into the target, the target would come out wrong. Every conditional opcode is run with both flag values, so a swapped condition shows up on `taken`. A second copy of the block in mask mode is driven with power-of-two sizes and must match the general-remainder results.

// File: rtl/branch_target_unit.sv
module branch_target_unit #(
  parameter int AW        = 64,
  parameter bit POW2_SIZE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    opcode,
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] operand,
  input  logic [2:0]    width_code,
  input  logic          zflag,
  input  logic [AW-1:0] mem_size,
  output logic          out_valid,
  output logic [AW-1:0] next_ptr,
  output logic          taken
);
  localparam int NB = AW / 8;

  localparam logic [7:0] OP_JABS  = 8'd4;
  localparam logic [7:0] OP_JABSZ = 8'd5;
  localparam logic [7:0] OP_JABSN = 8'd6;
  localparam logic [7:0] OP_JREL  = 8'd7;
  localparam logic [7:0] OP_JRELZ = 8'd8;
  localparam logic [7:0] OP_JRELN = 8'd9;

  int            nbytes;
  logic [AW-1:0] wmask;
  logic [AW-1:0] field;
  logic          sign;
  logic [AW-1:0] offset;
  logic          is_abs, is_rel, go;
  logic [AW-1:0] chosen;
  logic [AW-1:0] reduced;

  always_comb begin
    case (width_code)
      3'd1:    nbytes = 1;
      3'd2:    nbytes = 2;
      3'd3:    nbytes = 4;
      default: nbytes = 8;
    endcase
    if (nbytes > NB) nbytes = NB;
    for (int i = 0; i < NB; i++)
      wmask[i*8 +: 8] = (i < nbytes) ? 8'hFF : 8'h00;
  end

  assign field  = operand & wmask;
  assign sign   = operand[nbytes*8-1];
  assign offset = sign ? (field | ~wmask) : field;

  assign is_abs = (opcode == OP_JABS) || (opcode == OP_JABSZ) || (opcode == OP_JABSN);
  assign is_rel = (opcode == OP_JREL) || (opcode == OP_JRELZ) || (opcode == OP_JRELN);

  always_comb begin
    case (opcode)
      OP_JABS, OP_JREL:   go = 1'b1;
      OP_JABSZ, OP_JRELZ: go = zflag;
      OP_JABSN, OP_JRELN: go = ~zflag;
      default:            go = 1'b0;
    endcase
  end

  always_comb begin
    chosen = ptr;
    if (go && is_abs) chosen = field;
    if (go && is_rel) chosen = ptr + offset;
  end

  generate
    if (POW2_SIZE) begin : g_mask
      assign reduced = chosen & (mem_size - 1'b1);
    end else begin : g_mod
      assign reduced = (mem_size == '0) ? chosen : (chosen % mem_size);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      next_ptr  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        taken    <= go;
        next_ptr <= reduced;
      end
    end
  end
endmodule

// File: rtl/branch_target_unit_chk.sv
module branch_target_unit_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [7:0]    opcode,
  input logic          zflag,
  input logic [AW-1:0] mem_size,
  input logic          out_valid,
  input logic [AW-1:0] next_ptr,
  input logic          taken
);
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_ABS_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 8'd4) |=> taken); // R3
  AST_ABS_ZCOND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 8'd5) |=> (taken == $past(zflag))); // R4
  AST_REL_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 8'd7) |=> taken); // R5
  AST_REL_NZCOND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 8'd9) |=> (taken == !$past(zflag))); // R6
  AST_NONBRANCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode < 8'd4 || opcode > 8'd9)) |=> !taken); // R7
  AST_BELOW_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mem_size != '0) |=> (next_ptr < $past(mem_size))); // R8
endmodule

bind branch_target_unit branch_target_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
  .zflag(zflag), .mem_size(mem_size), .out_valid(out_valid),
  .next_ptr(next_ptr), .taken(taken)
);

// File: tb/test_branch_target_unit.sv
module test_branch_target_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = '0;
  logic [63:0] ptr = '0, operand = '0, size_a = 64'd1, size_b = 64'd1;
  logic [2:0]  width_code = '0;
  logic        zflag = 1'b0;
  logic        ov_a, tk_a, ov_b, tk_b;
  logic [63:0] np_a, np_b;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  branch_target_unit i_branch_target_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode), .ptr(ptr),
    .operand(operand), .width_code(width_code), .zflag(zflag), .mem_size(size_a),
    .out_valid(ov_a), .next_ptr(np_a), .taken(tk_a));

  branch_target_unit #(.POW2_SIZE(1'b1)) i_branch_target_unit_pow2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode), .ptr(ptr),
    .operand(operand), .width_code(width_code), .zflag(zflag), .mem_size(size_b),
    .out_valid(ov_b), .next_ptr(np_b), .taken(tk_b));

  function automatic int nbytes_of(input logic [2:0] w);
    case (w)
      3'd1: return 1;
      3'd2: return 2;
      3'd3: return 4;
      default: return 8;
    endcase
  endfunction

  function automatic logic exp_taken(input logic [7:0] op, input logic z);
    case (op)
      8'd4, 8'd7: return 1'b1;
      8'd5, 8'd8: return z;
      8'd6, 8'd9: return !z;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [63:0] exp_next(input logic [7:0] op, input logic [63:0] p,
      input logic [63:0] opd, input logic [2:0] w, input logic z, input logic [63:0] sz);
    int n = nbytes_of(w);
    logic [63:0] m = (n == 8) ? ~64'd0 : ((64'd1 << (8*n)) - 64'd1);
    logic [63:0] f = opd & m;
    logic [63:0] s = opd[8*n-1] ? (f | ~m) : f;
    logic [63:0] v = p;
    if (exp_taken(op, z)) begin
      if (op >= 8'd4 && op <= 8'd6) v = f;
      if (op >= 8'd7 && op <= 8'd9) v = p + s;
    end
    return v % sz;
  endfunction

  function automatic string tag_of(input logic [7:0] op, input logic [2:0] w);
    if (w == 3'd0 || w > 3'd4) return "R10";
    case (op)
      8'd4: return "R3";
      8'd5, 8'd6: return "R4";
      8'd7: return "R5";
      8'd8, 8'd9: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_one(input logic [7:0] op, input logic [63:0] p, input logic [63:0] opd,
      input logic [2:0] w, input logic z, input logic [63:0] sa, input logic [63:0] sb,
      input string tag);
    @(negedge clk);
    opcode = op; ptr = p; operand = opd; width_code = w; zflag = z;
    size_a = sa; size_b = sb; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", {63'd0, ov_a}, 64'd1);
    check(tag, {63'd0, tk_a}, {63'd0, exp_taken(op, z)});
    check(tag, np_a, exp_next(op, p, opd, w, z, sa));
    check("R8", np_b, exp_next(op, p, opd, w, z, sb));
    check("R8", {63'd0, tk_b}, {63'd0, exp_taken(op, z)});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R1", {62'd0, ov_a, tk_a}, 64'd0);
    check("R1", np_a, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", {63'd0, ov_a}, 64'd0);

    for (int op = 4; op <= 9; op++)
      for (int w = 1; w <= 4; w++)
        for (int z = 0; z <= 1; z++)
          run_one(8'(op), 64'h0000_0000_0000_1000, 64'hF0E0_D0C0_B0A0_9080,
                  3'(w), 1'(z), 64'd100000, 64'd65536, tag_of(8'(op), 3'(w)));

    run_one(8'd7, 64'd5, 64'h0000_0000_0000_00F0, 3'd1, 1'b0, 64'd100, 64'd64, "R5");
    run_one(8'd9, 64'd3, 64'h1234_5678_9ABC_FFFE, 3'd2, 1'b0, 64'd7, 64'd8, "R6");
    run_one(8'd4, 64'd0, 64'h0000_0000_0000_AB00, 3'd1, 1'b0, 64'd1000, 64'd1024, "R9");
    run_one(8'd4, 64'd0, 64'hFFFF_FFFF_0102_0304, 3'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF,
            64'h8000_0000_0000_0000, "R9");
    run_one(8'd5, 64'd77, 64'd12, 3'd2, 1'b0, 64'd50, 64'd32, "R7");
    run_one(8'd2, 64'd999, 64'd12, 3'd2, 1'b1, 64'd10, 64'd16, "R7");
    run_one(8'd7, 64'd10, 64'hFFFF_FFFF_FFFF_FFFB, 3'd0, 1'b0, 64'd1000, 64'd512, "R10");
    run_one(8'd4, 64'd10, 64'h0000_0000_0000_0200, 3'd6, 1'b0, 64'd1000, 64'd4096, "R10");

    for (int k = 0; k < 1500; k++) begin
      logic [7:0]  op = (($urandom % 4) == 0) ? 8'($urandom % 16) : 8'(4 + $urandom % 6);
      logic [2:0]  w  = (($urandom % 8) == 0) ? 3'($urandom) : 3'(1 + $urandom % 4);
      logic [63:0] sa = (($urandom % 2) == 0) ? 64'(1 + $urandom % 70000)
                                              : {$urandom, $urandom} | 64'd1;
      logic [63:0] sb = 64'd1 << ($urandom % 64);
      run_one(op, {$urandom, $urandom}, {$urandom, $urandom}, w, 1'($urandom),
              sa, sb, tag_of(op, w));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule